// File: doc/BRIEF.md
# Two-Wire Slave Register Port for a 12-bit Converter

This block is a two-wire (I2C) bus slave that owns the 16-bit control word of a 12-bit digital-to-analog converter. It watches SCL and SDA through two-flop synchronisers and pulls SDA low through an output-enable, which suits an open-drain pad. It recognises Start, Repeated Start and Stop. A transfer begins with a 7-bit device address that is compared against a strapping input.

In a write, the master sends the word as an upper byte followed by a lower byte. The upper byte carries a 2-bit power-down mode and the top four code bits. Word pairs may follow each other without re-addressing. A finished word is committed only once its lower byte has been acknowledged. A word written with mode zero also moves the converter code output and raises a one-cycle update strobe. A word with any other mode is kept for readback and leaves the code output where it was. In a read, the slave returns the stored word as an upper byte and then a lower byte.

Top module: `i2c_dac_regif`

## Requirements
- R1: The first byte after a Start is the 7-bit address, MSB first, followed by a direction bit (0 write, 1 read). When the address equals `devAddr`, the slave pulls SDA low for the whole ninth clock.
- R2: On an address mismatch the slave does not acknowledge and keeps SDA released until the next Start. Its data bytes get no acknowledge, and both the stored word and the outputs stay unchanged.
- R3: In a write, the upper byte is laid out as bits [5:4] = power-down mode and bits [3:0] = code bits 11..8. Bits [7:6] are ignored. The lower byte is code bits 7..0. The slave acknowledges every data byte.
- R4: A word is committed only after its lower byte has been acknowledged. Each mode-zero commit gives exactly one single-cycle `updateStb` pulse.
- R5: An upper byte that is cut off by a Stop or a Repeated Start before its lower byte is thrown away. The stored word, the mode and the code output keep their earlier values.
- R6: After a lower byte, a further upper/lower pair in the same transfer forms a new word without a new address. Any number of words may stream this way.
- R7: `pwrMode` shows the mode field of the last committed word unchanged: 00 normal, 01 2.5 kΩ load, 10 100 kΩ load, 11 high impedance.
- R8: A commit with a nonzero mode updates the stored word and `pwrMode`, leaves `dacCode` unchanged and gives no strobe.
- R9: A commit with mode 00 loads `dacCode` with the new 12-bit value in the same cycle as the `updateStb` pulse. `pwrMode` then reads 00.
- R10: A read returns the upper byte {00, mode, code[11:8]} and then the lower byte code[7:0], MSB first. A master ACK asks for the next byte, and the sequence wraps back to the upper byte after the lower byte. After a master NACK the slave releases SDA.
- R11: A Repeated Start sends the slave back to address decoding, and it releases SDA at once.
- R12: SDA high-to-low while SCL is high is a Start, and SDA low-to-high while SCL is high is a Stop. The slave changes its SDA drive only while SCL is low.
- R13: After reset, `dacCode` = 0, `pwrMode` = 00, `updateStb` = 0 and `sdaOe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| devAddr | input | 7 | Device address that the bus address is compared with |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |
| dacCode | output | 12 | Converter code, moved only by mode-zero commits |
| pwrMode | output | 2 | Power-down mode of the last committed word |
| updateStb | output | 1 | One-cycle pulse when `dacCode` is loaded |

## Verification
The assertions assume a master that obeys the bus rules. It changes SDA only while SCL is low, except to form Start and Stop, and it never forms a Start or Stop while the slave is pulling SDA low. They also assume each SCL phase lasts several system clocks, so that the synchronised edges arrive in order. The bench master keeps every SCL phase at five or more clocks and drives SDA only in the low phase. It releases SDA before each acknowledge slot and wired-ANDs its own drive with `sdaOe`, so the stimulus always stays inside these assumptions.

// File: rtl/i2c_dac_pkg.sv
package i2c_dac_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } linkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // capture SDA into receive shifter
    logic loadHigh;  // hold received upper byte
    logic commit;    // upper + lower complete and acknowledged
  } dpStrobe_t;

endpackage

// File: rtl/i2c_dac_linesync.sv
module i2c_dac_linesync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclChain;
  logic [TOP:0] sdaChain;
  logic         sclPrev;
  logic         sdaPrev;

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain[0] <= sclIn;
          sdaChain[0] <= sdaIn;
        end
      end
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[TOP-1:0], sclIn};
          sdaChain <= {sdaChain[TOP-1:0], sdaIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclChain[TOP];
      sdaPrev <= sdaChain[TOP];
    end
  end

  assign sclLvl    = sclChain[TOP];
  assign sdaLvl    = sdaChain[TOP];
  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startSeen = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopSeen  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/i2c_dac_ctrl.sv
module i2c_dac_ctrl
  import i2c_dac_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclRise,
  input  logic                sclFall,
  input  logic                startSeen,
  input  logic                stopSeen,
  input  logic                sdaLvl,
  input  logic [BYTE_W-1:0]   rxByte,
  input  logic [BYTE_W-1:0]   txByte,
  input  logic [ADDR_W-1:0]   devAddr,
  output dpStrobe_t           stb,
  output logic                rdLow,
  output logic                sdaOe
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

  linkState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic             isRead;
  logic             wantLow;
  logic             masterAck;
  logic [2:0]       txIdx;

  assign txIdx = ~bitCnt[2:0];

  always_comb begin
    stb = '0;
    if (!startSeen && !stopSeen) begin
      case (state)
        ST_ADDR, ST_WR_BYTE: stb.shiftIn = sclRise;
        ST_WR_ACK: begin
          stb.loadHigh = sclFall & ~wantLow;
          stb.commit   = sclFall & wantLow;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_ADDR_ACK, ST_WR_ACK: sdaOe = 1'b1;
      ST_RD_BYTE:             sdaOe = ~txByte[txIdx];
      default:                sdaOe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      wantLow   <= 1'b0;
      rdLow     <= 1'b0;
      masterAck <= 1'b0;
    end else if (startSeen) begin
      state   <= ST_ADDR;
      bitCnt  <= '0;
      wantLow <= 1'b0;
      rdLow   <= 1'b0;
    end else if (stopSeen) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      wantLow <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (sclFall && bitCnt == FULL_CNT) begin
            bitCnt <= '0;
            if (rxByte[BYTE_W-1:1] == devAddr) begin
              state  <= ST_ADDR_ACK;
              isRead <= rxByte[0];
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitCnt  <= '0;
            rdLow   <= 1'b0;
            wantLow <= 1'b0;
            state   <= isRead ? ST_RD_BYTE : ST_WR_BYTE;
          end
        end
        ST_WR_BYTE: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (sclFall && bitCnt == FULL_CNT) begin
            bitCnt <= '0;
            state  <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            wantLow <= ~wantLow;
            state   <= ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (sclFall) begin
            if (bitCnt == LAST_TX) begin
              bitCnt <= '0;
              state  <= ST_RD_ACK;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) masterAck <= ~sdaLvl;
          else if (sclFall) begin
            if (masterAck) begin
              rdLow <= ~rdLow;
              state <= ST_RD_BYTE;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_dac_dpath.sv
module i2c_dac_dpath
  import i2c_dac_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaLvl,
  input  dpStrobe_t         stb,
  input  logic              rdLow,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] txByte,
  output logic [CODE_W-1:0] dacCode,
  output logic [MODE_W-1:0] pwrMode,
  output logic              updateStb
);

  localparam int HI_W   = CODE_W - BYTE_W;
  localparam int HOLD_W = MODE_W + HI_W;
  localparam int PAD_W  = BYTE_W - HOLD_W;

  logic [BYTE_W-1:0] shiftReg;
  logic [HOLD_W-1:0] hiHold;
  logic [CODE_W-1:0] wordCode;
  logic [MODE_W-1:0] wordMode;
  logic [CODE_W-1:0] newCode;
  logic [MODE_W-1:0] newMode;

  assign newCode = {hiHold[HI_W-1:0], shiftReg};
  assign newMode = hiHold[HOLD_W-1:HI_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      hiHold   <= '0;
    end else begin
      if (stb.shiftIn)  shiftReg <= {shiftReg[BYTE_W-2:0], sdaLvl};
      if (stb.loadHigh) hiHold   <= shiftReg[HOLD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCode  <= '0;
      wordMode  <= '0;
      dacCode   <= '0;
      updateStb <= 1'b0;
    end else begin
      updateStb <= 1'b0;
      if (stb.commit) begin
        wordCode <= newCode;
        wordMode <= newMode;
        if (newMode == '0) begin
          dacCode   <= newCode;
          updateStb <= 1'b1;
        end
      end
    end
  end

  assign rxByte  = shiftReg;
  assign pwrMode = wordMode;
  assign txByte  = rdLow ? wordCode[BYTE_W-1:0]
                         : {{PAD_W{1'b0}}, wordMode, wordCode[CODE_W-1:BYTE_W]};

endmodule

// File: rtl/i2c_dac_regif.sv
module i2c_dac_regif
  import i2c_dac_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int MODE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [CODE_W-1:0] dacCode,
  output logic [MODE_W-1:0] pwrMode,
  output logic              updateStb
);

  logic              sclLvl;
  logic              sdaLvl;
  logic              sclRise;
  logic              sclFall;
  logic              startSeen;
  logic              stopSeen;
  dpStrobe_t         stb;
  logic              rdLow;
  logic [BYTE_W-1:0] rxByte;
  logic [BYTE_W-1:0] txByte;

  i2c_dac_linesync #(.SYNC_STAGES(SYNC_STAGES)) line_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  i2c_dac_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .txByte(txByte), .devAddr(devAddr),
    .stb(stb), .rdLow(rdLow), .sdaOe(sdaOe)
  );

  i2c_dac_dpath #(.CODE_W(CODE_W), .MODE_W(MODE_W)) dpath_i (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .stb(stb), .rdLow(rdLow),
    .rxByte(rxByte), .txByte(txByte), .dacCode(dacCode),
    .pwrMode(pwrMode), .updateStb(updateStb)
  );

endmodule

// File: rtl/i2c_dac_regif_chk.sv
module i2c_dac_regif_chk #(
  parameter int CODE_W = 12,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclLvl,
  input logic              startSeen,
  input logic              sdaOe,
  input logic              updateStb,
  input logic [CODE_W-1:0] dacCode,
  input logic [MODE_W-1:0] pwrMode
);

  // R12: drive changes only follow a low SCL sample
  a_r12_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !$past(sclLvl));

  // R11: a (repeated) start frees the line
  a_r11_start_releases: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> !sdaOe);

  // R4: strobe is a single cycle
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |=> !updateStb);

  // R8: the code output only moves together with the strobe
  a_r8_code_moves_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacCode) |-> updateStb);

  // R9: strobe only for a normal-mode word
  a_r9_strobe_normal_mode: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |-> (pwrMode == '0));

endmodule

bind i2c_dac_regif i2c_dac_regif_chk #(.CODE_W(CODE_W), .MODE_W(MODE_W)) chk_i (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .startSeen(startSeen),
  .sdaOe(sdaOe), .updateStb(updateStb), .dacCode(dacCode), .pwrMode(pwrMode)
);

// File: tb/i2c_dac_regif_tb_top.sv
module i2c_dac_regif_tb_top;

  localparam int Q = 5;
  localparam int H = 8;
  localparam logic [6:0] DEV = 7'h4C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic updateStb;
  logic [11:0] dacCode;
  logic [1:0] pwrMode;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaOe;

  always #10 clk = ~clk;

  i2c_dac_regif dut_i (
    .clk(clk), .rstN(rstN), .devAddr(DEV), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .dacCode(dacCode), .pwrMode(pwrMode), .updateStb(updateStb)
  );

  typedef struct packed {
    logic [11:0] code;
    logic [1:0]  mode;
  } exp_t;

  exp_t expQ[$];
  exp_t popE;
  int checks = 0;
  int errors = 0;
  int r12Bad = 0;
  logic prevOe = 1'b0;
  logic stbPrev = 1'b0;
  logic [11:0] mCode = '0;
  logic [11:0] mOut = '0;
  logic [1:0]  mMode = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b1; waitClk(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitClk(Q);
      sclM = 1'b1; waitClk(H);
      sclM = 1'b0; waitClk(Q);
    end
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(H / 2);
    ack = !sdaLine;
    waitClk(H / 2);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic getByte(input bit ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(Q);
      sclM = 1'b1; waitClk(H / 2);
      b[i] = sdaLine;
      waitClk(H / 2);
      sclM = 1'b0;
    end
    sdaM = ackIt ? 1'b0 : 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(H);
    sclM = 1'b0; waitClk(Q);
    sdaM = 1'b1;
  endtask

  task automatic addrPhase(input logic [6:0] a, input bit rd, input bit expAck,
                           input string req);
    bit ack;
    busStart();
    sendByte({a, rd}, ack);
    chk(ack == expAck, req, "address acknowledge", ack, expAck);
  endtask

  // driver: updates the model and pushes the expected strobe
  task automatic putWord(input logic [15:0] w);
    bit ack;
    sendByte(w[15:8], ack);
    chk(ack, "R3", "upper byte acknowledge", ack, 1);
    mMode = w[13:12];
    mCode = w[11:0];
    if (mMode == 2'b00) begin
      mOut = mCode;
      expQ.push_back({mCode, 2'b00});
    end
    sendByte(w[7:0], ack);
    chk(ack, "R3", "lower byte acknowledge", ack, 1);
  endtask

  task automatic readCheck(input bit wrapOnce);
    logic [7:0] b;
    logic [7:0] upExp;
    upExp = {2'b00, mMode, mCode[11:8]};
    addrPhase(DEV, 1'b1, 1'b1, "R1");
    getByte(1'b1, b);
    chk(b == upExp, "R10", "read upper byte", b, upExp);
    getByte(wrapOnce, b);
    chk(b == mCode[7:0], "R10", "read lower byte", b, mCode[7:0]);
    if (wrapOnce) begin
      getByte(1'b0, b);
      chk(b == upExp, "R10", "read wraps to upper byte", b, upExp);
    end
    waitClk(2);
    chk(sdaOe == 1'b0, "R10", "released after master NACK", sdaOe, 0);
    busStop();
  endtask

  // monitor: pops expected commits as strobes appear
  always @(negedge clk) begin
    if (rstN) begin
      if (updateStb) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R4", "unexpected update strobe", 1, 0);
        end else begin
          popE = expQ.pop_front();
          chk(dacCode == popE.code, "R4", "code at strobe", dacCode, popE.code);
          chk(pwrMode == popE.mode, "R9", "mode at strobe", pwrMode, popE.mode);
        end
        if (stbPrev) chk(1'b0, "R4", "strobe longer than one cycle", 2, 1);
      end
      if (sdaOe !== prevOe && sclM) r12Bad++;
    end
    stbPrev = updateStb;
    prevOe  = sdaOe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired (all requirements): actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    waitClk(5);
    chk(dacCode == 12'h000, "R13", "reset code", dacCode, 0);
    chk(pwrMode == 2'b00, "R13", "reset mode", pwrMode, 0);
    chk(updateStb == 1'b0, "R13", "reset strobe", updateStb, 0);
    chk(sdaOe == 1'b0, "R13", "reset sda drive", sdaOe, 0);
    rstN = 1'b1;
    waitClk(5);

    // R1 R3 R4 R9: single word
    addrPhase(DEV, 1'b0, 1'b1, "R1");
    putWord(16'h0A5C);
    busStop();
    chk(dacCode == 12'hA5C, "R9", "code after normal write", dacCode, 12'hA5C);
    chk(expQ.size() == 0, "R4", "strobe seen for word", expQ.size(), 0);

    // R6: streaming words; top pad bits set in the first (R3)
    addrPhase(DEV, 1'b0, 1'b1, "R6");
    putWord(16'hC123);
    putWord(16'h0FFF);
    putWord(16'h0000);
    putWord(16'h0BEE);
    busStop();
    chk(dacCode == 12'hBEE, "R6", "code after stream", dacCode, 12'hBEE);
    chk(expQ.size() == 0, "R6", "all streamed words committed", expQ.size(), 0);

    // R7 R8: power-down modes keep the code output
    addrPhase(DEV, 1'b0, 1'b1, "R8");
    putWord(16'h1234);
    busStop();
    chk(pwrMode == 2'b01, "R7", "mode 01", pwrMode, 1);
    chk(dacCode == mOut, "R8", "code held in power-down", dacCode, mOut);
    readCheck(1'b0);
    addrPhase(DEV, 1'b0, 1'b1, "R8");
    putWord(16'h2345);
    busStop();
    chk(pwrMode == 2'b10, "R7", "mode 10", pwrMode, 2);
    chk(dacCode == mOut, "R8", "code held in power-down", dacCode, mOut);
    addrPhase(DEV, 1'b0, 1'b1, "R8");
    putWord(16'h3456);
    busStop();
    chk(pwrMode == 2'b11, "R7", "mode 11", pwrMode, 3);
    readCheck(1'b1);
    addrPhase(DEV, 1'b0, 1'b1, "R9");
    putWord(16'h0777);
    busStop();
    chk(dacCode == 12'h777, "R9", "wake-up code", dacCode, 12'h777);
    chk(pwrMode == 2'b00, "R9", "wake-up mode", pwrMode, 0);

    // R5: word cut by Stop
    addrPhase(DEV, 1'b0, 1'b1, "R5");
    putWord(16'h0321);
    sendByte(8'h1F, ack);
    busStop();
    chk(dacCode == 12'h321, "R5", "code after cut word", dacCode, 12'h321);
    chk(pwrMode == 2'b00, "R5", "mode after cut word", pwrMode, 0);
    readCheck(1'b0);

    // R5 R11: word cut by Repeated Start, then re-addressed write
    addrPhase(DEV, 1'b0, 1'b1, "R5");
    sendByte(8'h1A, ack);
    addrPhase(DEV, 1'b0, 1'b1, "R11");
    putWord(16'h0456);
    busStop();
    chk(dacCode == 12'h456, "R11", "code after repeated start", dacCode, 12'h456);
    chk(pwrMode == 2'b00, "R5", "cut upper byte ignored", pwrMode, 0);

    // R11: write then repeated start into a read
    addrPhase(DEV, 1'b0, 1'b1, "R11");
    putWord(16'h0ABC);
    readCheck(1'b0);

    // R2: foreign address, write and read
    addrPhase(DEV ^ 7'h01, 1'b0, 1'b0, "R2");
    sendByte(8'h01, ack);
    chk(ack == 1'b0, "R2", "data byte not acknowledged", ack, 0);
    sendByte(8'h99, ack);
    chk(ack == 1'b0, "R2", "data byte not acknowledged", ack, 0);
    busStop();
    chk(dacCode == 12'hABC, "R2", "code unchanged", dacCode, 12'hABC);
    readCheck(1'b0);
    addrPhase(DEV ^ 7'h40, 1'b1, 1'b0, "R2");
    getByte(1'b0, b);
    chk(b == 8'hFF, "R2", "line left released on read", b, 8'hFF);
    busStop();

    waitClk(20);
    chk(expQ.size() == 0, "R4", "no missing strobes", expQ.size(), 0);
    chk(r12Bad == 0, "R12", "sda drive changes while scl high", r12Bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule